// File: doc/BRIEF.md
# Four-Channel Converter Read-Strobe Interface

This block is the digital front end of a four-channel, 8-bit parallel-output converter, seen from the converter. A host drives active-low chip-select and read strobes and a channel address. The block answers with an 8-bit result on a data bus, which has an output enable for tri-state drive. It also drives a ready line, modelled as an open-drain pull-down enable, and an active-low interrupt. The analog path is modelled by one 8-bit sample word per channel and a conversion timer with a fixed number of cycles. When the timer expires, the result latch takes the sample of the latched channel.

A mode pin selects one of two read modes. In wait mode, a read starts a conversion and holds the host with the ready line. The bus stays undriven until the result is ready, and the result then appears during the same read. In no-wait mode, a read returns the result left by the previous conversion at once. When that read ends, the block latches the address and starts the next conversion. A second read collects the new result and clears the interrupt.

All inputs are treated as synchronous to `clk`. Strobe edges are found by comparing each input with its value one cycle earlier.

Top module: `adcif_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `data_oe`=0, `rdy_oe`=0, `int_n`=1 and `addr_err`=0. The result latch resets to 0.
- R2: In wait mode (`mode_nowait`=0), the first cycle in which `cs_n` and `rd_n` are both low starts a conversion of the channel on `addr`. `data_oe` stays 0 for `CONV_CYC` cycles. In the next cycle, `data_oe`=1 and `data_out` equals that channel's sample taken at the end of the conversion. Channel g is `samples[8g+7:8g]`.
- R3: In wait mode, `rdy_oe` goes to 1 the cycle after `cs_n` falls and returns to 0 in the cycle the result is driven.
- R4: `int_n` goes to 0 in the cycle a conversion's result is latched. It returns to 1 the cycle after `cs_n` or `rd_n` rises.
- R5: In no-wait mode (`mode_nowait`=1), `data_oe`=1 from the cycle after the read strobe begins, and `data_out` shows the result of the previous conversion. The cycle the strobe ends, the address is latched and a conversion starts. `int_n` falls `CONV_CYC`+1 cycles after the strobe is released.
- R6: In no-wait mode, `rdy_oe` stays 0.
- R7: In no-wait mode, a second read returns the new result, and `int_n` is 1 the cycle after that read ends.
- R8: A read that starts or ends while a conversion is running does not restart or extend it. The result keeps the channel of the running conversion.
- R9: In wait mode, a change of `addr` while the strobes are low, after the first strobe cycle, sets `addr_err`. The flag stays set until reset. A stable address leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 2 | Channel address |
| mode_nowait | input | 1 | 0 = wait mode, 1 = no-wait mode |
| samples | input | 32 | Per-channel sample words, channel g at bits 8g+7:8g |
| data_out | output | 8 | Result latch contents |
| data_oe | output | 1 | Data bus drive enable |
| rdy_oe | output | 1 | Ready pull-down enable (1 = ready low) |
| int_n | output | 1 | Conversion-done interrupt, active low |
| addr_err | output | 1 | Sticky flag for an address change during a wait-mode read |

## Verification
Some rules are checked by the assertions on every cycle. Ready stays released in no-wait mode. In wait mode the bus is never driven while a conversion runs. The interrupt falls only as the timer finishes and rises only after a strobe rises. A conversion always loads the full count, and the address-error flag is sticky. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle of each output change, the returned sample per channel and the one-read delay of no-wait mode. They also cover a read dropped into a running conversion and leaving its channel unchanged, and the address-error flag under a changed address.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  typedef enum logic {
    MODE_WAIT   = 1'b0,
    MODE_NOWAIT = 1'b1
  } rdmode_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/adcif_strobe.sv
module adcif_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  output logic strobe,
  output logic strobe_prev,
  output logic strobe_rise,
  output logic strobe_fall,
  output logic cs_fall,
  output logic release_edge
);
  logic cs_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
      rd_q <= rd_n;
    end
  end

  assign strobe       = ~cs_n & ~rd_n;
  assign strobe_prev  = ~cs_q & ~rd_q;
  assign strobe_rise  = strobe & ~strobe_prev;
  assign strobe_fall  = ~strobe & strobe_prev;
  assign cs_fall      = ~cs_n & cs_q;
  assign release_edge = (cs_n & ~cs_q) | (rd_n & ~rd_q);
endmodule

// File: rtl/adcif_timer.sv
module adcif_timer #(
  parameter int unsigned CONV_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int unsigned CW = adcif_pkg::cnt_width(CONV_CYC);
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYC - 1);

  logic [CW-1:0] cnt;

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2 / R8: every conversion begins from the full count
  assert_full_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cnt == LOAD));
endmodule

// File: rtl/adcif_datapath.sv
module adcif_datapath #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 8,
  localparam int unsigned AW = adcif_pkg::cnt_width(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH*W-1:0] samples,
  input  logic [AW-1:0]   addr,
  input  logic            ch_load,
  input  logic            capture,
  output logic [AW-1:0]   ch,
  output logic [W-1:0]    result
);
  logic [W-1:0] lane [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = samples[g*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch     <= '0;
      result <= '0;
    end else begin
      if (ch_load) ch <= addr;
      if (capture) result <= lane[ch];
    end
  end
endmodule

// File: rtl/adcif_top.sv
module adcif_top #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned W        = 8,
  parameter int unsigned CONV_CYC = 16,
  localparam int unsigned AW      = adcif_pkg::cnt_width(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [AW-1:0]    addr,
  input  logic             mode_nowait,
  input  logic [NCH*W-1:0] samples,
  output logic [W-1:0]     data_out,
  output logic             data_oe,
  output logic             rdy_oe,
  output logic             int_n,
  output logic             addr_err
);
  import adcif_pkg::*;

  rdmode_e md;
  logic nowait;
  logic strobe, strobe_prev, strobe_rise, strobe_fall, cs_fall, release_edge;
  logic start, busy, fin, fresh;
  logic [AW-1:0] ch;

  assign md     = rdmode_e'(mode_nowait);
  assign nowait = (md == MODE_NOWAIT);

  adcif_strobe u_strobe (
    .clk, .rst, .cs_n, .rd_n,
    .strobe, .strobe_prev, .strobe_rise, .strobe_fall, .cs_fall, .release_edge
  );

  // wait mode converts on strobe entry, no-wait mode on strobe exit
  assign start = ~busy & (nowait ? strobe_fall : strobe_rise);

  adcif_timer #(.CONV_CYC(CONV_CYC)) u_timer (
    .clk, .rst, .start, .busy, .finish(fin)
  );

  adcif_datapath #(.NCH(NCH), .W(W)) u_dp (
    .clk, .rst, .samples, .addr,
    .ch_load(start), .capture(fin), .ch, .result(data_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      fresh    <= 1'b0;
      rdy_oe   <= 1'b0;
      int_n    <= 1'b1;
      addr_err <= 1'b0;
    end else begin
      data_oe <= strobe & (nowait | fresh | fin);

      if (!strobe)           fresh <= 1'b0;
      else if (fin && !nowait) fresh <= 1'b1;

      if (nowait || fin)     rdy_oe <= 1'b0;
      else if (cs_n)         rdy_oe <= 1'b0;
      else if (cs_fall)      rdy_oe <= 1'b1;

      if (fin)               int_n <= 1'b0;
      else if (release_edge) int_n <= 1'b1;

      if (!nowait && strobe && strobe_prev && (addr != ch))
        addr_err <= 1'b1;
    end
  end

  assert_rdy_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    nowait |=> !rdy_oe);

  assert_bus_hiz_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !nowait |=> !(data_oe && busy));

  assert_int_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> (!busy && $past(busy)));

  assert_int_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(int_n) |-> $past(cs_n | rd_n));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> addr_err);
endmodule

// File: tb/adcif_top_tb.sv
`timescale 1ns/1ps
module adcif_top_tb_top;
  localparam int NCH  = 4;
  localparam int W    = 8;
  localparam int CONV = 16;

  logic clk = 1'b0;
  logic rst, cs_n, rd_n, mode_nowait;
  logic [1:0] addr;
  logic [W-1:0] smp [NCH];
  logic [NCH*W-1:0] samples;
  logic [W-1:0] data_out;
  logic data_oe, rdy_oe, int_n, addr_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] prev_res;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) samples[i*W +: W] = smp[i];

  adcif_top #(.NCH(NCH), .W(W), .CONV_CYC(CONV)) dut_i (
    .clk, .rst, .cs_n, .rd_n, .addr, .mode_nowait, .samples,
    .data_out, .data_oe, .rdy_oe, .int_n, .addr_err
  );

  function automatic logic [W-1:0] exp_sample(input int c);
    return smp[c];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic check_reset_state(input string req);
    check(data_oe == 0, req, data_oe, 0);
    check(rdy_oe == 0, req, rdy_oe, 0);
    check(int_n == 1, req, int_n, 1);
    check(addr_err == 0, req, addr_err, 0);
  endtask

  // wait-mode read; early_cs drops chip-select one cycle before read
  task automatic read_wait(input int c, input bit early_cs);
    addr = c[1:0];
    cs_n = 1'b0;
    if (early_cs) begin
      tick();
      check(rdy_oe == 1, "R3 ready on cs fall", rdy_oe, 1);
      check(data_oe == 0, "R2 idle bus", data_oe, 0);
    end
    rd_n = 1'b0;
    tick();
    check(rdy_oe == 1, "R3 ready held", rdy_oe, 1);
    check(data_oe == 0, "R2 bus hiz start", data_oe, 0);
    repeat (CONV - 1) tick();
    check(data_oe == 0, "R2 bus hiz end", data_oe, 0);
    tick();
    check(data_oe == 1, "R2 bus driven", data_oe, 1);
    check(data_out == exp_sample(c), "R2 result", data_out, exp_sample(c));
    check(int_n == 0, "R4 int low", int_n, 0);
    check(rdy_oe == 0, "R3 ready released", rdy_oe, 0);
    prev_res = exp_sample(c);
    rd_n = 1'b1;
    cs_n = 1'b1;
    tick();
    check(int_n == 1, "R4 int cleared", int_n, 1);
    check(data_oe == 0, "R2 bus released", data_oe, 0);
  endtask

  // no-wait read returning prev_res, then converting channel c
  task automatic read_nowait(input int c);
    addr = c[1:0];
    cs_n = 1'b0;
    rd_n = 1'b0;
    tick();
    check(data_oe == 1, "R5 bus driven", data_oe, 1);
    check(data_out == prev_res, "R7 previous result", data_out, prev_res);
    check(rdy_oe == 0, "R6 ready quiet", rdy_oe, 0);
    tick();
    rd_n = 1'b1;
    cs_n = 1'b1;
    tick();
    check(int_n == 1, "R7 int cleared", int_n, 1);
    check(data_oe == 0, "R5 bus released", data_oe, 0);
    repeat (CONV - 1) tick();
    check(int_n == 1, "R5 int before end", int_n, 1);
    tick();
    check(int_n == 0, "R5 int at end", int_n, 0);
    check(rdy_oe == 0, "R6 ready quiet", rdy_oe, 0);
    prev_res = exp_sample(c);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1; cs_n = 1; rd_n = 1; addr = 0; mode_nowait = 0;
    for (int i = 0; i < NCH; i++) smp[i] = W'(8'h11 * (i + 1));
    repeat (3) tick();
    check_reset_state("R1 in reset");
    check(data_out == 0, "R1 result", data_out, 0);
    rst = 0;
    tick();
    check_reset_state("R1 after reset");

    // directed wait-mode reads on every channel
    for (int c = 0; c < NCH; c++) read_wait(c, c == 2);
    smp[0] = 8'h00; read_wait(0, 0);
    smp[3] = 8'hFF; read_wait(3, 1);

    // random wait-mode reads
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < NCH; i++) smp[i] = W'($urandom);
      read_wait(int'($urandom_range(0, NCH - 1)), 1'($urandom));
    end
    check(addr_err == 0, "R9 stable address", addr_err, 0);

    // no-wait mode: first read returns the last wait-mode result
    mode_nowait = 1;
    tick();
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < NCH; i++) smp[i] = W'($urandom);
      read_nowait(int'($urandom_range(0, NCH - 1)));
    end

    // R8: read dropped into a running conversion is ignored
    smp[1] = 8'hA5; smp[2] = 8'h5A;
    addr = 2'd1; cs_n = 0; rd_n = 0;
    tick(); tick();
    cs_n = 1; rd_n = 1;              // conversion of channel 1 starts
    tick(); tick();
    addr = 2'd2; cs_n = 0; rd_n = 0; // read while busy
    tick();
    check(data_oe == 1, "R8 busy read drives", data_oe, 1);
    check(data_out == prev_res, "R8 busy read old result", data_out, prev_res);
    tick();
    cs_n = 1; rd_n = 1;
    repeat (CONV - 4) tick();
    check(int_n == 1, "R8 no extension before", int_n, 1);
    tick();
    check(int_n == 0, "R8 original end time", int_n, 0);
    prev_res = 8'hA5;
    read_nowait(0);                  // returns channel 1, not 2
    check(addr_err == 0, "R9 no error in no-wait", addr_err, 0);

    // R9: address change inside a wait-mode read
    mode_nowait = 0;
    tick();
    addr = 2'd0; cs_n = 0; rd_n = 0;
    tick();
    addr = 2'd3;
    tick();
    check(addr_err == 1, "R9 error set", addr_err, 1);
    repeat (CONV) tick();
    cs_n = 1; rd_n = 1;
    repeat (3) tick();
    check(addr_err == 1, "R9 error sticky", addr_err, 1);

    rst = 1;
    tick();
    rst = 0;
    tick();
    check_reset_state("R1 second reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule